// File: doc/BRIEF.md
# Reference Clock Switch Sequencer

This controller changes the physical reference clock that feeds either a transmit PLL or a receive clock-data-recovery unit. It does this by driving a memory-mapped reconfiguration port with a fixed series of accesses. A request carries a target selector and a logical clock index. For each selection multiplexer that must change, the block reads an 8-bit lookup register that maps the logical clock to a physical input. It then writes that byte, unchanged, into the multiplexer register.

A PLL switch touches two multiplexers, always the first one before the second. A recovery-unit switch touches one multiplexer. Its lookup address is a base plus the logical index. Requests that cannot be served complete at once with an error and cause no bus traffic. This happens when the index exceeds the supported source count, or when fewer than two reference clocks are configured.

The bus side is a simple master. It has an address, read and write strobes, write data, read data and a wait-request input. Each access is held steady until wait-request drops.

Top module: `refclk_switch_seq`

## Requirements
- R1: After reset, busy_o, done_o, err_o, bus_read_o and bus_write_o are all low.
- R2: A PLL request (tgt_cdr_i = 0) with index k performs four accesses in this order: read 0x117+k, write 0x114, read 0x11D+k, write 0x11C. Index 3 therefore reads 0x11A and 0x120.
- R3: A recovery-unit request (tgt_cdr_i = 1) with index k performs two accesses: read 0x16A+k, then write CDR_MUX_ADDR (default 0x150).
- R4: Each write carries exactly the byte returned by the read just before it, with no masking or merging.
- R5: While bus_waitreq_i is high during an access, the address, the strobe and the write data stay unchanged. Read data is taken in the cycle in which bus_waitreq_i is low.
- R6: A request whose index is not below MAX_REFCLK (default 5) raises done_o and err_o together one cycle later and issues no read or write.
- R7: With NUM_REFCLK of 1 or less, every request raises done_o and err_o one cycle later and issues no bus access.
- R8: busy_o is high from the cycle after an accepted request through the cycle in which the last write completes. done_o is then high for exactly one cycle with err_o low, and busy_o is low in that cycle.
- R9: A request presented while busy_o is high is ignored and adds no bus accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Switch request, sampled when idle |
| tgt_cdr_i | input | 1 | Target: 0 = PLL, 1 = recovery unit |
| idx_i | input | IDX_W | Logical reference clock index |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Error flag, valid with done_o |
| bus_addr_o | output | ADDR_W | Access address |
| bus_read_o | output | 1 | Read strobe |
| bus_write_o | output | 1 | Write strobe |
| bus_wdata_o | output | DATA_W | Write data |
| bus_rdata_i | input | DATA_W | Read data |
| bus_waitreq_i | input | 1 | Slave stall, holds the current access |

## Verification
The bench builds two copies. The first uses the defaults: three configured clocks, five supported sources and a 3-bit index. This lets indices 5 to 7 reach the out-of-range rejection, while valid indices up to 4 walk every lookup offset. The second copy is set to a single configured clock, so that the rejection for a too-small clock count is reachable at all. A responder with a per-access stall length drives both the zero-wait and the multi-cycle-hold cases.

// File: rtl/refclk_sw_pkg.sv
package refclk_sw_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } seq_state_e;

  // Lookup register address for a logical clock: base plus index
  function automatic int unsigned offset_addr(input int unsigned base,
                                              input int unsigned idx);
    return base + idx;
  endfunction

  // Index must address one of the supported sources
  function automatic logic idx_in_range(input int unsigned idx,
                                        input int unsigned max_src);
    return idx < max_src;
  endfunction

  // Switching needs at least two configured clocks
  function automatic logic switch_allowed(input int unsigned count);
    return count > 1;
  endfunction

endpackage

// File: rtl/refclk_sw_plan.sv
module refclk_sw_plan
  import refclk_sw_pkg::*;
#(
  parameter int unsigned ADDR_W        = 10,
  parameter int unsigned IDX_W         = 3,
  parameter int unsigned PLL_LUT0_BASE = 32'h117,
  parameter int unsigned PLL_LUT1_BASE = 32'h11D,
  parameter int unsigned PLL_MUX0_ADDR = 32'h114,
  parameter int unsigned PLL_MUX1_ADDR = 32'h11C,
  parameter int unsigned CDR_LUT_BASE  = 32'h16A,
  parameter int unsigned CDR_MUX_ADDR  = 32'h150
) (
  input  logic              tgt_cdr,
  input  logic [IDX_W-1:0]  idx,
  input  logic              step,
  output logic [ADDR_W-1:0] lut_addr,
  output logic [ADDR_W-1:0] mux_addr,
  output logic              last_step
);

  int unsigned lut_base;
  int unsigned mux_sel;

  always_comb begin
    if (tgt_cdr) begin
      lut_base = CDR_LUT_BASE;
      mux_sel  = CDR_MUX_ADDR;
    end else if (!step) begin
      lut_base = PLL_LUT0_BASE;
      mux_sel  = PLL_MUX0_ADDR;
    end else begin
      lut_base = PLL_LUT1_BASE;
      mux_sel  = PLL_MUX1_ADDR;
    end
  end

  assign lut_addr  = ADDR_W'(offset_addr(lut_base, 32'(idx)));
  assign mux_addr  = ADDR_W'(mux_sel);
  // recovery unit has one mux, PLL has two
  assign last_step = tgt_cdr | step;

endmodule

// File: rtl/refclk_sw_hold.sv
module refclk_sw_hold #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    dout <= '0;
    else if (load) dout <= din;
  end

endmodule

// File: rtl/refclk_sw_ctrl.sv
module refclk_sw_ctrl
  import refclk_sw_pkg::*;
#(
  parameter int unsigned IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic             req_tgt_cdr,
  input  logic [IDX_W-1:0] req_idx,
  input  logic             req_ok,
  input  logic             waitreq,
  input  logic             last_step,
  output seq_state_e       state,
  output logic             step,
  output logic             tgt_cdr_q,
  output logic [IDX_W-1:0] idx_q,
  output logic             accept,
  output logic             reject,
  output logic             rd_fire,
  output logic             wr_fire,
  output logic             done,
  output logic             err
);

  assign accept  = (state == ST_IDLE)  && req && req_ok;
  assign reject  = (state == ST_IDLE)  && req && !req_ok;
  assign rd_fire = (state == ST_READ)  && !waitreq;
  assign wr_fire = (state == ST_WRITE) && !waitreq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      step      <= 1'b0;
      tgt_cdr_q <= 1'b0;
      idx_q     <= '0;
      done      <= 1'b0;
      err       <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            state     <= ST_READ;
            step      <= 1'b0;
            tgt_cdr_q <= req_tgt_cdr;
            idx_q     <= req_idx;
          end else if (reject) begin
            done <= 1'b1;
            err  <= 1'b1;
          end
        end
        ST_READ: begin
          if (rd_fire) state <= ST_WRITE;
        end
        ST_WRITE: begin
          if (wr_fire) begin
            if (last_step) begin
              state <= ST_IDLE;
              done  <= 1'b1;
            end else begin
              step  <= 1'b1;
              state <= ST_READ;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/refclk_switch_seq.sv
module refclk_switch_seq
  import refclk_sw_pkg::*;
#(
  parameter int unsigned ADDR_W        = 10,
  parameter int unsigned DATA_W        = 8,
  parameter int unsigned IDX_W         = 3,
  parameter int unsigned MAX_REFCLK    = 5,
  parameter int unsigned NUM_REFCLK    = 3,
  parameter int unsigned PLL_LUT0_BASE = 32'h117,
  parameter int unsigned PLL_LUT1_BASE = 32'h11D,
  parameter int unsigned PLL_MUX0_ADDR = 32'h114,
  parameter int unsigned PLL_MUX1_ADDR = 32'h11C,
  parameter int unsigned CDR_LUT_BASE  = 32'h16A,
  parameter int unsigned CDR_MUX_ADDR  = 32'h150
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic              tgt_cdr_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic              bus_read_o,
  output logic              bus_write_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  input  logic [DATA_W-1:0] bus_rdata_i,
  input  logic              bus_waitreq_i
);

  localparam logic CFG_OK = switch_allowed(NUM_REFCLK);

  // named internal events, observed by the bound checker
  seq_state_e        state;
  logic              step;
  logic              tgt_cdr_q;
  logic [IDX_W-1:0]  idx_q;
  logic              req_ok;
  logic              accept;
  logic              reject;
  logic              rd_fire;
  logic              wr_fire;
  logic              last_step;
  logic [ADDR_W-1:0] lut_addr;
  logic [ADDR_W-1:0] mux_addr;
  logic [DATA_W-1:0] held_byte;

  assign req_ok = CFG_OK && idx_in_range(32'(idx_i), MAX_REFCLK);

  refclk_sw_ctrl #(
    .IDX_W(IDX_W)
  ) ctrl_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .req         (req_i),
    .req_tgt_cdr (tgt_cdr_i),
    .req_idx     (idx_i),
    .req_ok      (req_ok),
    .waitreq     (bus_waitreq_i),
    .last_step   (last_step),
    .state       (state),
    .step        (step),
    .tgt_cdr_q   (tgt_cdr_q),
    .idx_q       (idx_q),
    .accept      (accept),
    .reject      (reject),
    .rd_fire     (rd_fire),
    .wr_fire     (wr_fire),
    .done        (done_o),
    .err         (err_o)
  );

  refclk_sw_plan #(
    .ADDR_W        (ADDR_W),
    .IDX_W         (IDX_W),
    .PLL_LUT0_BASE (PLL_LUT0_BASE),
    .PLL_LUT1_BASE (PLL_LUT1_BASE),
    .PLL_MUX0_ADDR (PLL_MUX0_ADDR),
    .PLL_MUX1_ADDR (PLL_MUX1_ADDR),
    .CDR_LUT_BASE  (CDR_LUT_BASE),
    .CDR_MUX_ADDR  (CDR_MUX_ADDR)
  ) plan_i (
    .tgt_cdr   (tgt_cdr_q),
    .idx       (idx_q),
    .step      (step),
    .lut_addr  (lut_addr),
    .mux_addr  (mux_addr),
    .last_step (last_step)
  );

  refclk_sw_hold #(
    .DATA_W(DATA_W)
  ) hold_i (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (rd_fire),
    .din   (bus_rdata_i),
    .dout  (held_byte)
  );

  assign busy_o      = (state != ST_IDLE);
  assign bus_read_o  = (state == ST_READ);
  assign bus_write_o = (state == ST_WRITE);
  assign bus_addr_o  = bus_read_o ? lut_addr : mux_addr;
  assign bus_wdata_o = held_byte;

endmodule

// File: rtl/refclk_switch_seq_chk.sv
module refclk_switch_seq_chk #(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              err_o,
  input logic [ADDR_W-1:0] bus_addr_o,
  input logic              bus_read_o,
  input logic              bus_write_o,
  input logic [DATA_W-1:0] bus_wdata_o,
  input logic [DATA_W-1:0] bus_rdata_i,
  input logic              bus_waitreq_i,
  input logic              accept,
  input logic              reject,
  input logic              rd_fire,
  input logic              wr_fire
);

  a_r5_hold_read: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_read_o && bus_waitreq_i) |=> (bus_read_o && $stable(bus_addr_o)));

  a_r5_hold_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_write_o && bus_waitreq_i) |=>
      (bus_write_o && $stable(bus_addr_o) && $stable(bus_wdata_o)));

  a_r5_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_read_o && bus_write_o));

  a_r4_wdata_from_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |=> (bus_write_o && bus_wdata_o == $past(bus_rdata_i)));

  a_r6_reject_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    reject |=> (done_o && err_o && !bus_read_o && !bus_write_o));

  a_r8_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy_o);

  a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  a_r8_busy_ends_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !wr_fire) |=> busy_o);

  a_r9_no_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && req_i) |-> !accept);

endmodule

bind refclk_switch_seq refclk_switch_seq_chk #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W)
) chk_i (.*);

// File: tb/refclk_switch_seq_tb.sv
`timescale 1ns/1ps
module refclk_switch_seq_tb_top;

  localparam int ADDR_W = 10;
  localparam int DATA_W = 8;
  localparam int IDX_W  = 3;

  typedef struct packed {
    logic       cdr;
    logic [2:0] idx;
    logic [3:0] wt;
    logic [7:0] seed;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{1'b0, 3'd3, 4'd0, 8'h11},
    '{1'b0, 3'd0, 4'd2, 8'h5A},
    '{1'b1, 3'd0, 4'd0, 8'h33},
    '{1'b1, 3'd2, 4'd3, 8'h0F},
    '{1'b0, 3'd4, 4'd1, 8'hC3},
    '{1'b1, 3'd4, 4'd0, 8'h77}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic              req, tgt, req1;
  logic [IDX_W-1:0]  idx;
  logic              busy, done, err, rd, wr, waitreq;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] wdata, rdata;
  logic              busy1, done1, err1, rd1, wr1;
  logic [ADDR_W-1:0] addr1;
  logic [DATA_W-1:0] wdata1;

  refclk_switch_seq dut_i (
    .clk(clk), .rst_n(rst_n), .req_i(req), .tgt_cdr_i(tgt), .idx_i(idx),
    .busy_o(busy), .done_o(done), .err_o(err), .bus_addr_o(addr),
    .bus_read_o(rd), .bus_write_o(wr), .bus_wdata_o(wdata),
    .bus_rdata_i(rdata), .bus_waitreq_i(waitreq));

  refclk_switch_seq #(.NUM_REFCLK(1)) dut1_i (
    .clk(clk), .rst_n(rst_n), .req_i(req1), .tgt_cdr_i(1'b0), .idx_i(3'd1),
    .busy_o(busy1), .done_o(done1), .err_o(err1), .bus_addr_o(addr1),
    .bus_read_o(rd1), .bus_write_o(wr1), .bus_wdata_o(wdata1),
    .bus_rdata_i(8'h00), .bus_waitreq_i(1'b0));

  // responder
  logic [7:0] mem [0:1023];
  int wait_len = 0;
  int wcnt = 0;
  assign waitreq = (rd || wr) && (wcnt < wait_len);
  assign rdata   = mem[addr];
  always @(posedge clk) begin
    if ((rd || wr) && waitreq) wcnt <= wcnt + 1;
    else                       wcnt <= 0;
  end

  // monitor: sampled on the falling edge
  int         log_n = 0;
  logic       log_wr   [0:15];
  int         log_addr [0:15];
  int         log_data [0:15];
  int         hold_viol = 0;
  int         traffic1 = 0;
  logic       p_wait = 0, p_rd = 0, p_wr = 0;
  logic [ADDR_W-1:0] p_addr = '0;
  logic [DATA_W-1:0] p_wdata = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (p_wait && (rd != p_rd || wr != p_wr || addr != p_addr ||
                     (p_wr && wdata != p_wdata)))
        hold_viol++;
      if ((rd || wr) && !waitreq && log_n < 16) begin
        log_wr[log_n]   = wr;
        log_addr[log_n] = int'(addr);
        log_data[log_n] = int'(wdata);
        if (wr) mem[addr] = wdata;
        log_n++;
      end
      if (rd1 || wr1) traffic1++;
    end
    p_wait  = (rd || wr) && waitreq;
    p_rd    = rd;
    p_wr    = wr;
    p_addr  = addr;
    p_wdata = wdata;
  end

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic fill(input logic [7:0] seed);
    for (int a = 0; a < 1024; a++) mem[a] = 8'(a * 7 + int'(seed));
  endtask

  function automatic int lut_of(input logic cdr, input int k, input int s);
    if (cdr) return 'h16A + k;
    return (s == 0) ? ('h117 + k) : ('h11D + k);
  endfunction

  function automatic int mux_of(input logic cdr, input int s);
    if (cdr) return 'h150;
    return (s == 0) ? 'h114 : 'h11C;
  endfunction

  task automatic pulse_req(input logic c, input logic [2:0] k);
    @(negedge clk);
    req = 1'b1; tgt = c; idx = k;
    @(negedge clk);
    req = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    req = 0; tgt = 0; idx = '0; req1 = 0;
    fill(8'h00);
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!busy && !done && !err && !rd && !wr, "R1", "outputs in reset",
          {busy, done, err, rd, wr}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !done && !err && !rd && !wr, "R1", "outputs after reset",
          {busy, done, err, rd, wr}, 0);

    // table walk: R2 / R3 / R4 / R8
    foreach (VECS[v]) begin
      int n, bcnt;
      string tg;
      n  = VECS[v].cdr ? 2 : 4;
      tg = VECS[v].cdr ? "R3" : "R2";
      fill(VECS[v].seed);
      wait_len = int'(VECS[v].wt);
      log_n = 0;
      pulse_req(VECS[v].cdr, VECS[v].idx);
      bcnt = 0;
      while (busy && bcnt < 200) begin
        bcnt++;
        @(negedge clk);
      end
      check(bcnt == n * (int'(VECS[v].wt) + 1), "R8", "busy cycles",
            bcnt, n * (int'(VECS[v].wt) + 1));
      check(done && !err, "R8", "done without error", {done, err}, 2);
      check(log_n == n, tg, "access count", log_n, n);
      for (int s = 0; s < n / 2; s++) begin
        int la, ma;
        la = lut_of(VECS[v].cdr, int'(VECS[v].idx), s);
        ma = mux_of(VECS[v].cdr, s);
        check(!log_wr[2*s] && log_addr[2*s] == la, tg, "lookup read addr",
              log_addr[2*s], la);
        check(log_wr[2*s+1] && log_addr[2*s+1] == ma, tg, "mux write addr",
              log_addr[2*s+1], ma);
        check(log_data[2*s+1] == ((la * 7 + int'(VECS[v].seed)) & 'hFF), "R4",
              "written byte", log_data[2*s+1], (la * 7 + int'(VECS[v].seed)) & 'hFF);
      end
      @(negedge clk);
      check(!done, "R8", "done is one cycle", done, 0);
    end

    // R5 hold while stalled
    check(hold_viol == 0, "R5", "hold violations", hold_viol, 0);

    // R6 out-of-range indices
    wait_len = 0;
    for (int k = 5; k < 8; k++) begin
      log_n = 0;
      pulse_req(1'b0, 3'(k));
      check(done && err && !busy, "R6", "reject pulse", {done, err, busy}, 6);
      repeat (3) @(negedge clk);
      check(log_n == 0, "R6", "no traffic", log_n, 0);
    end

    // R7 single configured clock
    @(negedge clk); req1 = 1'b1;
    @(negedge clk); req1 = 1'b0;
    check(done1 && err1 && !busy1, "R7", "reject pulse", {done1, err1, busy1}, 6);
    repeat (3) @(negedge clk);
    check(traffic1 == 0, "R7", "no traffic", traffic1, 0);

    // R9 request while busy
    fill(8'h21);
    wait_len = 1;
    log_n = 0;
    pulse_req(1'b0, 3'd1);
    @(negedge clk);
    req = 1'b1; tgt = 1'b1; idx = 3'd2;
    @(negedge clk);
    req = 1'b0;
    while (busy) @(negedge clk);
    repeat (4) @(negedge clk);
    check(log_n == 4, "R9", "access count", log_n, 4);
    check(log_addr[0] == 'h118 && log_addr[2] == 'h11E, "R9", "first request kept",
          log_addr[2], 'h11E);
    check(!busy, "R9", "idle afterwards", busy, 0);

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule